// File: doc/BRIEF.md
# Dual-Clock FIFO with Loadable Threshold Flags

This block is a first-in first-out buffer between two unrelated clock domains. A producer pushes 9-bit words on the write clock and a consumer pops them on the read clock. Each side drives its own active-low status flags: empty and near-empty on the read side, full and near-full on the write side. The depth is a parameter and must be a power of two. Pointers cross between the domains as Gray code through two-stage synchronisers.

A dual-role control pin is captured while reset is held. If it is high during reset, the pin is a second write enable. If it is low during reset, the pin becomes a load strobe. With the strobe low, write-clock cycles store `wr_data` into the two threshold registers, and read-clock cycles return those registers on `rd_data`. The FIFO itself is not touched. An output-enable input stands in for a three-state bus. It gates the data output and drives a separate drive-enable flag.

Top module: `dcfifo_progflag`

## Requirements
- R1: On a rising `wr_clk` edge a word is pushed only when `wr_en_a_n` is 0, `wr_en_b_ld` is 1 and `full_n` is 1.
- R2: The role of `wr_en_b_ld` is taken from its level while `rst_n` is 0. Level 1 selects second write enable: driving it 0 then blocks pushes and has no other effect. Level 0 selects load strobe.
- R3: In load-strobe role, a `wr_clk` edge with `wr_en_b_ld` = 0 and `wr_en_a_n` = 0 stores `wr_data` into a threshold register and not into the FIFO. The registers are visited in the rotating order near-empty threshold, then near-full threshold, one 9-bit slice per edge, least significant slice first.
- R4: In load-strobe role, an `rd_clk` edge with `wr_en_b_ld` = 0 and both read enables 0 places the next threshold slice on the data output, in the same rotating order. The FIFO read pointer is not moved.
- R5: On a rising `rd_clk` edge a word is popped only when `rd_en_a_n` and `rd_en_b_n` are both 0 and `empty_n` is 1. The popped word is registered onto `rd_data` at that edge, and words leave in the order they entered.
- R6: All flags are active low. `empty_n` and `near_empty_n` are registered on `rd_clk`, and `full_n` and `near_full_n` on `wr_clk`. A change made by the other domain shows in a flag within four edges of the observing clock.
- R7: `near_empty_n` is 0 when the stored count is at or below the near-empty threshold. `near_full_n` is 0 when the free space is at or below the near-full threshold.
- R8: After reset the FIFO is empty: `empty_n` = 0, `full_n` = 1, `rd_data` = 0. Both thresholds are 7, and both register-access sequences restart at the near-empty threshold.
- R9: With `out_en_n` = 1, `rd_data_drive` is 0 and `rd_data` reads 0. With `out_en_n` = 0, `rd_data_drive` is 1 and `rd_data` shows the held output word.
- R10: A push while full and a pop while empty are ignored. The output word is held, and later traffic is returned intact and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, seen synchronously by each clock |
| wr_en_a_n | input | 1 | Primary write enable, active low |
| wr_en_b_ld | input | 1 | Dual-role pin: second write enable or threshold load strobe |
| wr_data | input | DATA_W | Data written into the FIFO or a threshold register |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| rd_data | output | DATA_W | Registered output word, 0 while not enabled |
| rd_data_drive | output | 1 | High when the output would drive the bus |
| empty_n | output | 1 | Empty flag, active low, read domain |
| full_n | output | 1 | Full flag, active low, write domain |
| near_empty_n | output | 1 | Near-empty flag, active low, read domain |
| near_full_n | output | 1 | Near-full flag, active low, write domain |

## Verification
The assertions assume that both clocks run throughout reset, so that each domain samples the role pin and clears its pointers. They also assume that the dual-role pin stays at one level for the whole reset. Loads and the read-back of thresholds are assumed to happen while the FIFO is idle, because the threshold registers are read across domains without synchronisation. The stimulus holds reset over several edges of both clocks and keeps the pin steady until release. It changes thresholds only with no traffic pending, and it waits several edges of both clocks before any flag is compared.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int DCF_DATA_W    = 9;
    localparam int DCF_OFF_RESET = 7;

    typedef enum logic {
        PIN_WR_ENABLE   = 1'b0,
        PIN_LOAD_STROBE = 1'b1
    } pin_role_e;

    function automatic int slices_for(input int bits, input int slice_w);
        return (bits + slice_w - 1) / slice_w;
    endfunction

endpackage

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta = gray_in;
        s_d.stab = s_q.meta;
        if (!rst_n) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    // Gray to binary: each bit is the parity of itself and all higher bits
    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_out[i] = ^(s_q.stab >> i);
        end
    end

endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side import dcf_pkg::*; #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 16,
    parameter int PTR_W  = 5,
    parameter int NSLICE = 1
) (
    input  logic                         wclk,
    input  logic                         rst_n,
    input  logic                         wen_a_n,
    input  logic                         pin_b,
    input  logic [DATA_W-1:0]            din,
    input  logic [PTR_W-1:0]             rbin_sync,
    output logic [PTR_W-1:0]             wbin,
    output logic [PTR_W-1:0]             wgray,
    output logic                         ram_we,
    output logic                         full_n,
    output logic                         near_full_n,
    output logic [2*NSLICE-1:0][DATA_W-1:0] thr
);

    localparam int NREG  = 2 * NSLICE;
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int OFF_W = NSLICE * DATA_W;

    typedef struct packed {
        pin_role_e                     role;
        logic [PTR_W-1:0]              bin;
        logic [PTR_W-1:0]              gray;
        logic                          full;
        logic                          afull;
        logic [NREG-1:0][DATA_W-1:0]   thr;
        logic [SEL_W-1:0]              sel;
    } wr_t;

    wr_t w_d, w_q;

    logic             loading;
    logic             pushing;
    logic [PTR_W-1:0] used;
    logic [OFF_W-1:0] af_off;
    logic [OFF_W-1:0] free_ext;

    always_comb begin
        w_d     = w_q;
        loading = (w_q.role == PIN_LOAD_STROBE) && !pin_b && !wen_a_n;
        pushing = !wen_a_n && pin_b && !w_q.full;

        if (pushing) begin
            w_d.bin = w_q.bin + 1'b1;
        end
        w_d.gray = w_d.bin ^ (w_d.bin >> 1);

        if (loading) begin
            w_d.thr[w_q.sel] = din;
            w_d.sel = (w_q.sel == SEL_W'(NREG - 1)) ? '0 : w_q.sel + 1'b1;
        end

        af_off    = w_q.thr[NREG-1:NSLICE];
        used      = w_d.bin - rbin_sync;
        free_ext  = OFF_W'(PTR_W'(DEPTH) - used);
        w_d.full  = (used == PTR_W'(DEPTH));
        w_d.afull = (free_ext <= af_off);

        if (!rst_n) begin
            w_d             = '0;
            w_d.role        = pin_b ? PIN_WR_ENABLE : PIN_LOAD_STROBE;
            w_d.thr[0]      = DATA_W'(DCF_OFF_RESET);
            w_d.thr[NSLICE] = DATA_W'(DCF_OFF_RESET);
            w_d.afull       = (OFF_W'(DEPTH) <= OFF_W'(DCF_OFF_RESET));
        end
    end

    always_ff @(posedge wclk) begin
        w_q <= w_d;
    end

    assign wbin        = w_q.bin;
    assign wgray       = w_q.gray;
    assign ram_we      = pushing;
    assign full_n      = ~w_q.full;
    assign near_full_n = ~w_q.afull;
    assign thr         = w_q.thr;

endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side import dcf_pkg::*; #(
    parameter int DATA_W = 9,
    parameter int PTR_W  = 5,
    parameter int NSLICE = 1
) (
    input  logic                         rclk,
    input  logic                         rst_n,
    input  logic                         ren_a_n,
    input  logic                         ren_b_n,
    input  logic                         pin_b,
    input  logic [PTR_W-1:0]             wbin_sync,
    input  logic [DATA_W-1:0]            ram_rdata,
    input  logic [2*NSLICE-1:0][DATA_W-1:0] thr,
    output logic [PTR_W-1:0]             rbin,
    output logic [PTR_W-1:0]             rgray,
    output logic [DATA_W-1:0]            dout,
    output logic                         empty_n,
    output logic                         near_empty_n
);

    localparam int NREG  = 2 * NSLICE;
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int OFF_W = NSLICE * DATA_W;

    typedef struct packed {
        pin_role_e          role;
        logic [PTR_W-1:0]   bin;
        logic [PTR_W-1:0]   gray;
        logic               empty;
        logic               aempty;
        logic [SEL_W-1:0]   sel;
        logic [DATA_W-1:0]  dout;
    } rd_t;

    rd_t r_d, r_q;

    logic             strobe_low;
    logic             both_en;
    logic             peeking;
    logic             popping;
    logic [PTR_W-1:0] held;
    logic [OFF_W-1:0] ae_off;

    always_comb begin
        r_d        = r_q;
        strobe_low = (r_q.role == PIN_LOAD_STROBE) && !pin_b;
        both_en    = !ren_a_n && !ren_b_n;
        peeking    = strobe_low && both_en;
        popping    = both_en && !strobe_low && !r_q.empty;

        if (popping) begin
            r_d.bin  = r_q.bin + 1'b1;
            r_d.dout = ram_rdata;
        end
        r_d.gray = r_d.bin ^ (r_d.bin >> 1);

        if (peeking) begin
            r_d.dout = thr[r_q.sel];
            r_d.sel  = (r_q.sel == SEL_W'(NREG - 1)) ? '0 : r_q.sel + 1'b1;
        end

        ae_off     = thr[NSLICE-1:0];
        held       = wbin_sync - r_d.bin;
        r_d.empty  = (held == '0);
        r_d.aempty = (OFF_W'(held) <= ae_off);

        if (!rst_n) begin
            r_d        = '0;
            r_d.role   = pin_b ? PIN_WR_ENABLE : PIN_LOAD_STROBE;
            r_d.empty  = 1'b1;
            r_d.aempty = 1'b1;
        end
    end

    always_ff @(posedge rclk) begin
        r_q <= r_d;
    end

    assign rbin         = r_q.bin;
    assign rgray        = r_q.gray;
    assign dout         = r_q.dout;
    assign empty_n      = ~r_q.empty;
    assign near_empty_n = ~r_q.aempty;

endmodule

// File: rtl/dcfifo_progflag.sv
module dcfifo_progflag import dcf_pkg::*; #(
    parameter int DATA_W = DCF_DATA_W,
    parameter int DEPTH  = 16
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en_a_n,
    input  logic              wr_en_b_ld,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_a_n,
    input  logic              rd_en_b_n,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_data_drive,
    output logic              empty_n,
    output logic              full_n,
    output logic              near_empty_n,
    output logic              near_full_n
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;
    localparam int NSLICE = slices_for(PTR_W, DATA_W);

    logic [PTR_W-1:0]                 wbin, wgray, rbin, rgray;
    logic [PTR_W-1:0]                 rbin_w, wbin_r;
    logic                             ram_we;
    logic [DATA_W-1:0]                ram_rdata;
    logic [DATA_W-1:0]                dout_q;
    logic [2*NSLICE-1:0][DATA_W-1:0]  thr;

    dcf_wr_side #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .PTR_W  (PTR_W),
        .NSLICE (NSLICE)
    ) u_wr (
        .wclk        (wr_clk),
        .rst_n       (rst_n),
        .wen_a_n     (wr_en_a_n),
        .pin_b       (wr_en_b_ld),
        .din         (wr_data),
        .rbin_sync   (rbin_w),
        .wbin        (wbin),
        .wgray       (wgray),
        .ram_we      (ram_we),
        .full_n      (full_n),
        .near_full_n (near_full_n),
        .thr         (thr)
    );

    dcf_ram #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .wclk  (wr_clk),
        .we    (ram_we),
        .waddr (wbin[ADDR_W-1:0]),
        .wdata (wr_data),
        .raddr (rbin[ADDR_W-1:0]),
        .rdata (ram_rdata)
    );

    dcf_ptr_sync #(.W(PTR_W)) u_sync_r2w (
        .clk     (wr_clk),
        .rst_n   (rst_n),
        .gray_in (rgray),
        .bin_out (rbin_w)
    );

    dcf_ptr_sync #(.W(PTR_W)) u_sync_w2r (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .gray_in (wgray),
        .bin_out (wbin_r)
    );

    dcf_rd_side #(
        .DATA_W (DATA_W),
        .PTR_W  (PTR_W),
        .NSLICE (NSLICE)
    ) u_rd (
        .rclk         (rd_clk),
        .rst_n        (rst_n),
        .ren_a_n      (rd_en_a_n),
        .ren_b_n      (rd_en_b_n),
        .pin_b        (wr_en_b_ld),
        .wbin_sync    (wbin_r),
        .ram_rdata    (ram_rdata),
        .thr          (thr),
        .rbin         (rbin),
        .rgray        (rgray),
        .dout         (dout_q),
        .empty_n      (empty_n),
        .near_empty_n (near_empty_n)
    );

    assign rd_data_drive = ~out_en_n;
    assign rd_data       = out_en_n ? '0 : dout_q;

endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int PTR_W = 5,
    parameter int DEPTH = 16
) (
    input logic             wclk,
    input logic             rclk,
    input logic             rst_n,
    input logic             full_n,
    input logic             near_full_n,
    input logic             empty_n,
    input logic             near_empty_n,
    input logic [PTR_W-1:0] wbin,
    input logic [PTR_W-1:0] rbin,
    input logic [PTR_W-1:0] rbin_w,
    input logic [PTR_W-1:0] wbin_r
);

    logic [PTR_W-1:0] wfill, rfill;
    assign wfill = wbin - rbin_w;
    assign rfill = wbin_r - rbin;

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |=> $stable(wbin)); // R10

    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |=> $stable(rbin)); // R10

    AST_FULL_IS_NEAR_FULL: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !near_full_n); // R7

    AST_EMPTY_IS_NEAR_EMPTY: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !near_empty_n); // R7

    AST_WFILL_BOUND: assert property (@(posedge wclk) disable iff (!rst_n)
        wfill <= PTR_W'(DEPTH)); // R6

    AST_RFILL_BOUND: assert property (@(posedge rclk) disable iff (!rst_n)
        rfill <= PTR_W'(DEPTH)); // R6

endmodule

bind dcfifo_progflag dcf_checker #(
    .PTR_W (PTR_W),
    .DEPTH (DEPTH)
) u_chk (
    .wclk         (wr_clk),
    .rclk         (rd_clk),
    .rst_n        (rst_n),
    .full_n       (full_n),
    .near_full_n  (near_full_n),
    .empty_n      (empty_n),
    .near_empty_n (near_empty_n),
    .wbin         (wbin),
    .rbin         (rbin),
    .rbin_w       (rbin_w),
    .wbin_r       (wbin_r)
);

// File: tb/dcfifo_progflag_tb.sv
module dcfifo_progflag_tb;
    timeunit 1ns;
    timeprecision 100ps;

    logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic       wen1_n = 1'b1, pin2 = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b0;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       drive, empty_n, full_n, nempty_n, nfull_n;

    int checks = 0, fails = 0;
    bit done = 0;

    always #10 wclk = ~wclk;
    initial begin
        #0.5;
        forever #13 rclk = ~rclk;
    end

    dcfifo_progflag u_dut (
        .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n),
        .wr_en_a_n(wen1_n), .wr_en_b_ld(pin2), .wr_data(din),
        .rd_en_a_n(ren1_n), .rd_en_b_n(ren2_n), .out_en_n(oe_n),
        .rd_data(dout), .rd_data_drive(drive),
        .empty_n(empty_n), .full_n(full_n),
        .near_empty_n(nempty_n), .near_full_n(nfull_n)
    );

    // bit 9: 1 = pop and compare, 0 = push
    localparam logic [9:0] VEC [12] = '{
        {1'b0, 9'h101}, {1'b0, 9'h0A5}, {1'b0, 9'h1FF}, {1'b1, 9'h101},
        {1'b0, 9'h000}, {1'b1, 9'h0A5}, {1'b1, 9'h1FF}, {1'b0, 9'h13C},
        {1'b0, 9'h0C3}, {1'b1, 9'h000}, {1'b1, 9'h13C}, {1'b1, 9'h0C3}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge rclk);
        repeat (5) @(negedge wclk);
    endtask

    task automatic do_reset(input bit load_role);
        rst_n = 1'b0; pin2 = ~load_role; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        rst_n = 1'b1; pin2 = 1'b1;
        settle();
    endtask

    task automatic wr_cycle(input logic a_n, input logic p2, input logic [8:0] d);
        @(negedge wclk);
        wen1_n = a_n; pin2 = p2; din = d;
        @(negedge wclk);
        wen1_n = 1'b1; pin2 = 1'b1;
    endtask

    task automatic rd_cycle(input logic a_n, input logic b_n, input logic p2,
                            output logic [8:0] v);
        @(negedge rclk);
        ren1_n = a_n; ren2_n = b_n; pin2 = p2;
        @(negedge rclk);
        ren1_n = 1'b1; ren2_n = 1'b1; pin2 = 1'b1;
        v = dout;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [8:0] v;
        logic [8:0] last;

        // R8: reset state, two-enable role
        do_reset(1'b0);
        check(empty_n == 1'b0, "R8 empty after reset", empty_n, 0);
        check(full_n == 1'b1, "R8 not full after reset", full_n, 1);
        check(nempty_n == 1'b0, "R8 near-empty after reset", nempty_n, 0);
        check(nfull_n == 1'b1, "R8 not near-full after reset", nfull_n, 1);
        check(dout == 9'h000, "R8 output word after reset", dout, 0);
        check(drive == 1'b1, "R9 drive with out_en_n low", drive, 1);

        // R1 R5: table of pushes and pops
        for (int i = 0; i < 12; i++) begin
            if (VEC[i][9]) begin
                settle();
                rd_cycle(1'b0, 1'b0, 1'b1, v);
                check(v == VEC[i][8:0], "R5 FIFO order", v, VEC[i][8:0]);
            end else begin
                wr_cycle(1'b0, 1'b1, VEC[i][8:0]);
            end
        end
        settle();
        check(empty_n == 1'b0, "R5 empty after table", empty_n, 0);

        // R7 R1: fill with default thresholds (7)
        for (int i = 0; i < 8; i++) wr_cycle(1'b0, 1'b1, 9'(i * 3 + 1));
        settle();
        check(nfull_n == 1'b1, "R7 near-full clear at free 8", nfull_n, 1);
        wr_cycle(1'b0, 1'b1, 9'(8 * 3 + 1));
        settle();
        check(nfull_n == 1'b0, "R7 near-full set at free 7", nfull_n, 0);
        for (int i = 9; i < 16; i++) wr_cycle(1'b0, 1'b1, 9'(i * 3 + 1));
        settle();
        check(full_n == 1'b0, "R6 full after 16 pushes", full_n, 0);
        check(nempty_n == 1'b1, "R7 near-empty clear at 16", nempty_n, 1);
        wr_cycle(1'b0, 1'b1, 9'h1AA);   // R10 push while full
        settle();
        check(full_n == 1'b0, "R10 still full", full_n, 0);

        for (int i = 0; i < 16; i++) begin
            rd_cycle(1'b0, 1'b0, 1'b1, v);
            check(v == 9'(i * 3 + 1), "R10 contents after overflow attempt", v, 9'(i * 3 + 1));
            if (i == 7) check(nempty_n == 1'b1, "R7 near-empty clear at 8", nempty_n, 1);
            if (i == 8) check(nempty_n == 1'b0, "R7 near-empty set at 7", nempty_n, 0);
            last = v;
        end
        check(empty_n == 1'b0, "R6 empty after drain", empty_n, 0);
        rd_cycle(1'b0, 1'b0, 1'b1, v);  // R10 pop while empty
        check(v == last, "R10 output held on underflow", v, last);
        wr_cycle(1'b0, 1'b1, 9'h055);
        settle();
        rd_cycle(1'b0, 1'b0, 1'b1, v);
        check(v == 9'h055, "R10 pointers intact after underflow", v, 9'h055);

        // R2: second enable blocks pushes
        wr_cycle(1'b0, 1'b0, 9'h0EE);
        settle();
        check(empty_n == 1'b0, "R2 second enable low blocks push", empty_n, 0);
        // R5: one read enable is not enough
        wr_cycle(1'b0, 1'b1, 9'h0B7);
        settle();
        rd_cycle(1'b0, 1'b1, 1'b1, v);
        check(v == 9'h055 && empty_n == 1'b1, "R5 single read enable ignored", v, 9'h055);
        rd_cycle(1'b0, 1'b0, 1'b1, v);
        check(v == 9'h0B7, "R5 pop after both enables", v, 9'h0B7);

        // R9: output enable
        @(negedge rclk); oe_n = 1'b1; #1;
        check(drive == 1'b0, "R9 drive off", drive, 0);
        check(dout == 9'h000, "R9 data masked", dout, 0);
        oe_n = 1'b0; #1;
        check(dout == 9'h0B7, "R9 data back when enabled", dout, 9'h0B7);

        // Load-strobe role
        do_reset(1'b1);
        rd_cycle(1'b0, 1'b0, 1'b0, v);
        check(v == 9'd7, "R8 near-empty threshold default", v, 7);
        rd_cycle(1'b0, 1'b0, 1'b0, v);
        check(v == 9'd7, "R8 near-full threshold default", v, 7);
        wr_cycle(1'b0, 1'b0, 9'd2);
        wr_cycle(1'b0, 1'b0, 9'd3);
        settle();
        check(empty_n == 1'b0, "R3 loads do not enter FIFO", empty_n, 0);
        rd_cycle(1'b0, 1'b0, 1'b0, v);
        check(v == 9'd2, "R4 read back near-empty threshold", v, 2);
        rd_cycle(1'b0, 1'b0, 1'b0, v);
        check(v == 9'd3, "R4 read back near-full threshold", v, 3);
        check(empty_n == 1'b0, "R4 threshold read leaves FIFO", empty_n, 0);

        wr_cycle(1'b0, 1'b1, 9'h011);
        wr_cycle(1'b0, 1'b1, 9'h022);
        settle();
        check(nempty_n == 1'b0, "R7 near-empty at count 2 with threshold 2", nempty_n, 0);
        wr_cycle(1'b0, 1'b1, 9'h033);
        settle();
        check(nempty_n == 1'b1, "R7 near-empty clear at count 3", nempty_n, 1);
        for (int i = 3; i < 12; i++) wr_cycle(1'b0, 1'b1, 9'(i));
        settle();
        check(nfull_n == 1'b1, "R7 near-full clear at free 4", nfull_n, 1);
        wr_cycle(1'b0, 1'b1, 9'h0FF);
        settle();
        check(nfull_n == 1'b0, "R7 near-full set at free 3", nfull_n, 0);
        rd_cycle(1'b0, 1'b0, 1'b1, v);
        check(v == 9'h011, "R3 first data word intact", v, 9'h011);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule